// File: doc/BRIEF.md
# VGA Scan-Out with Startup Logo

This block produces a 640x480 VGA raster from a 25 MHz pixel clock. It fetches pixels from an external one-bit frame store of 640 columns by 240 rows. Each stored row is shown on two consecutive output lines. The block drives the store's read port with an address and takes the returned bit one clock later. It then delivers the monochrome video level and both sync pulses, all on the same clock cycle.

An internal raster generator keeps the column and row counters. It decodes the two active-low syncs and a visible-area flag from them. For a fixed number of pixel clocks after reset, a computed logo pattern is shown in place of the store's content. After that, the store's content takes over for good, until the next reset. The default hold is 250,000,000 clocks, which is ten seconds at 25 MHz. Every timing value is a parameter, so a bench can run a scaled-down raster.

Top module: `vga_scanout`

## Requirements
- R1: While rst_ni is low, video_o is 0, hsync_o and vsync_o are 1 and rd_addr_o is 0.
- R2: A line lasts H_VIS+H_FP+H_SYNC+H_BP clocks. hsync_o is low for exactly H_SYNC clocks, starting at column H_VIS+H_FP of the line.
- R3: A frame lasts V_VIS+V_FP+V_SYNC+V_BP lines. vsync_o is low for exactly V_SYNC whole lines, starting at line V_VIS+V_FP.
- R4: rd_addr_o follows the current raster position with no register in between. At a visible position it equals (row>>1)*H_VIS + column. In blanking it is 0. The raster starts at column 0, row 0 when reset is released.
- R5: The video_o, hsync_o and vsync_o values for a raster position appear two clocks after rd_addr_o presented that position. Outside the logo period, video_o equals the bit the store returned one clock after that address. In the first two clocks after reset, the outputs keep their reset levels.
- R6: Output rows 2k and 2k+1 read the same stored row k, so every stored line is shown twice.
- R7: video_o is 0 at every position outside the visible area.
- R8: For raster positions whose index since reset is below LOGO_CYCLES, visible pixels show the logo instead of the store. A logo pixel is lit when any of these holds: column < LOGO_BORDER, column >= H_VIS-LOGO_BORDER, row < LOGO_BORDER, row >= V_VIS-LOGO_BORDER, or bit LOGO_TILE_LG of the column differs from the same bit of the row. After LOGO_CYCLES the logo never returns until reset.
- R9: Asserting reset in the middle of a frame restarts the raster at position 0 and restarts the logo period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_addr_o | output | ADDR_W | Frame-store read address |
| rd_data_i | input | 1 | Frame-store read data, one clock after the address |
| video_o | output | 1 | Monochrome video level |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |

## Verification
The assertions assume that the frame store answers each address with its bit exactly one clock later, with no stall. They also assume that reset is the only thing that restarts the raster. The bench memory model is a registered hash of the address, so it always meets that one-clock latency. Its seed is changed only while reset is held, so no in-flight read can see mixed contents. Reset is asserted and released on falling clock edges. The pulse lengths and the release instant are drawn at random from a fixed seed.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;
  localparam int COL_W = 10;
  localparam int ROW_W = 10;

  typedef struct packed {
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
    logic             vis;
    logic             hs_n;
    logic             vs_n;
  } raster_t;

  localparam raster_t RASTER_IDLE = '{col: '0, row: '0, vis: 1'b0, hs_n: 1'b1, vs_n: 1'b1};
endpackage

// File: rtl/vga_timing_gen.sv
module vga_timing_gen
  import vga_scan_pkg::*;
#(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  output raster_t ras_o
);
  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;

  localparam logic [COL_W-1:0] H_LAST = COL_W'(H_TOTAL - 1);
  localparam logic [COL_W-1:0] H_VEND = COL_W'(H_VIS);
  localparam logic [COL_W-1:0] HS_BEG = COL_W'(H_VIS + H_FP);
  localparam logic [COL_W-1:0] HS_END = COL_W'(H_VIS + H_FP + H_SYNC);
  localparam logic [ROW_W-1:0] V_LAST = ROW_W'(V_TOTAL - 1);
  localparam logic [ROW_W-1:0] V_VEND = ROW_W'(V_VIS);
  localparam logic [ROW_W-1:0] VS_BEG = ROW_W'(V_VIS + V_FP);
  localparam logic [ROW_W-1:0] VS_END = ROW_W'(V_VIS + V_FP + V_SYNC);

  logic [COL_W-1:0] h_q;
  logic [ROW_W-1:0] v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (h_q == H_LAST) begin
      h_q <= '0;
      v_q <= (v_q == V_LAST) ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  always_comb begin
    ras_o.col  = h_q;
    ras_o.row  = v_q;
    ras_o.vis  = (h_q < H_VEND) && (v_q < V_VEND);
    ras_o.hs_n = !((h_q >= HS_BEG) && (h_q < HS_END));
    ras_o.vs_n = !((v_q >= VS_BEG) && (v_q < VS_END));
  end
endmodule

// File: rtl/vga_fetch_addr.sv
module vga_fetch_addr
  import vga_scan_pkg::*;
#(
  parameter int H_VIS  = 640,
  parameter int ADDR_W = 18
) (
  input  logic [COL_W-1:0]  col_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              vis_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] line_base;

  // two output rows share one stored row
  always_comb begin
    line_base = ADDR_W'(row_i >> 1) * ADDR_W'(H_VIS);
    addr_o    = vis_i ? line_base + ADDR_W'(col_i) : '0;
  end
endmodule

// File: rtl/vga_logo_timer.sv
module vga_logo_timer #(
  parameter int LOGO_CYCLES = 250_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic on_o
);
  localparam int CNT_W = $clog2(LOGO_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOGO_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign on_o = (cnt_q != LIMIT);
endmodule

// File: rtl/vga_logo_gen.sv
module vga_logo_gen
  import vga_scan_pkg::*;
#(
  parameter int H_VIS   = 640,
  parameter int V_VIS   = 480,
  parameter int BORDER  = 8,
  parameter int TILE_LG = 5
) (
  input  logic [COL_W-1:0] col_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             lit_o
);
  localparam logic [COL_W-1:0] C_LO = COL_W'(BORDER);
  localparam logic [COL_W-1:0] C_HI = COL_W'(H_VIS - BORDER);
  localparam logic [ROW_W-1:0] R_LO = ROW_W'(BORDER);
  localparam logic [ROW_W-1:0] R_HI = ROW_W'(V_VIS - BORDER);

  logic edge_hit;
  logic tile_hit;

  always_comb begin
    edge_hit = (col_i < C_LO) || (col_i >= C_HI) || (row_i < R_LO) || (row_i >= R_HI);
    tile_hit = col_i[TILE_LG] ^ row_i[TILE_LG];
    lit_o    = edge_hit || tile_hit;
  end
endmodule

// File: rtl/vga_scanout.sv
module vga_scanout
  import vga_scan_pkg::*;
#(
  parameter int H_VIS        = 640,
  parameter int H_FP         = 16,
  parameter int H_SYNC       = 96,
  parameter int H_BP         = 48,
  parameter int V_VIS        = 480,
  parameter int V_FP         = 10,
  parameter int V_SYNC       = 2,
  parameter int V_BP         = 33,
  parameter int LOGO_CYCLES  = 250_000_000,
  parameter int LOGO_BORDER  = 8,
  parameter int LOGO_TILE_LG = 5,
  localparam int STORE_PIX   = H_VIS * (V_VIS / 2),
  localparam int ADDR_W      = $clog2(STORE_PIX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_data_i,
  output logic              video_o,
  output logic              hsync_o,
  output logic              vsync_o
);
  raster_t ras_s0, ras_s1;
  logic    logo_s0, logo_s1;
  logic    logo_lit;
  logic    vis_s0, vis_s1;

  vga_timing_gen #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_timing (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ras_o (ras_s0)
  );

  vga_fetch_addr #(.H_VIS(H_VIS), .ADDR_W(ADDR_W)) u_addr (
    .col_i (ras_s0.col),
    .row_i (ras_s0.row),
    .vis_i (ras_s0.vis),
    .addr_o(rd_addr_o)
  );

  vga_logo_timer #(.LOGO_CYCLES(LOGO_CYCLES)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .on_o  (logo_s0)
  );

  // stage 1 lines up with the store's one-clock read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_s1  <= RASTER_IDLE;
      logo_s1 <= 1'b0;
    end else begin
      ras_s1  <= ras_s0;
      logo_s1 <= logo_s0;
    end
  end

  vga_logo_gen #(
    .H_VIS(H_VIS), .V_VIS(V_VIS), .BORDER(LOGO_BORDER), .TILE_LG(LOGO_TILE_LG)
  ) u_logo (
    .col_i(ras_s1.col),
    .row_i(ras_s1.row),
    .lit_o(logo_lit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      video_o <= 1'b0;
      hsync_o <= 1'b1;
      vsync_o <= 1'b1;
    end else begin
      video_o <= ras_s1.vis && (logo_s1 ? logo_lit : rd_data_i);
      hsync_o <= ras_s1.hs_n;
      vsync_o <= ras_s1.vs_n;
    end
  end

  assign vis_s0 = ras_s0.vis;
  assign vis_s1 = ras_s1.vis;
endmodule

// File: rtl/vga_scanout_chk.sv
module vga_scanout_chk #(
  parameter int H_SYNC    = 96,
  parameter int V_SYNC    = 2,
  parameter int ADDR_W    = 18,
  parameter int STORE_PIX = 153600
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hsync_o,
  input logic              vsync_o,
  input logic              video_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              vis_s0,
  input logic              vis_s1,
  input logic              logo_on
);
  logic [15:0] hs_low;
  logic [15:0] vs_lines;
  logic        hs_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_low   <= '0;
      vs_lines <= '0;
      hs_prev  <= 1'b1;
    end else begin
      hs_prev <= hsync_o;
      hs_low  <= hsync_o ? '0 : hs_low + 1'b1;
      if (vsync_o)                vs_lines <= '0;
      else if (hs_prev && !hsync_o) vs_lines <= vs_lines + 1'b1;
    end
  end

  a_r2_hsync_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hsync_o) |-> hs_low == 16'(H_SYNC));

  a_r3_vsync_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_o) |-> vs_lines == 16'(V_SYNC));

  a_r4_addr_blank_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vis_s0 |-> rd_addr_o == '0);

  a_r4_addr_in_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(rd_addr_o) < STORE_PIX);

  a_r7_dark_in_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vis_s1 |=> !video_o);

  a_r8_logo_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !logo_on |=> !logo_on);
endmodule

bind vga_scanout vga_scanout_chk #(
  .H_SYNC(H_SYNC), .V_SYNC(V_SYNC), .ADDR_W(ADDR_W), .STORE_PIX(STORE_PIX)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .hsync_o  (hsync_o),
  .vsync_o  (vsync_o),
  .video_o  (video_o),
  .rd_addr_o(rd_addr_o),
  .vis_s0   (vis_s0),
  .vis_s1   (vis_s1),
  .logo_on  (logo_s0)
);

// File: tb/tb_vga_scanout.sv
module tb_vga_scanout;
  localparam int HV = 64, HF = 4, HS = 8, HB = 4;
  localparam int VV = 20, VF = 2, VS = 2, VB = 2;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam int FR = HT * VT;
  localparam int LOGO = 3000, BRD = 2, TLG = 2;
  localparam int AW = $clog2(HV * (VV / 2));

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic [AW-1:0] rd_addr;
  logic          rd_q = 1'b0;
  logic          video, hs, vs;

  int unsigned seed;
  int n = 0, checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vga_scanout #(
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
    .LOGO_CYCLES(LOGO), .LOGO_BORDER(BRD), .LOGO_TILE_LG(TLG)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_addr_o(rd_addr), .rd_data_i(rd_q),
    .video_o(video), .hsync_o(hs), .vsync_o(vs)
  );

  function automatic logic pix_fn(int unsigned a);
    logic [31:0] t;
    t = a * 32'h9E3779B1;
    t = t ^ seed;
    return t[13] ^ t[7] ^ t[22];
  endfunction

  // registered-read store model
  always @(posedge clk) rd_q <= pix_fn(32'(rd_addr));

  function automatic logic logo_fn(int h, int v);
    return (h < BRD) || (h >= HV - BRD) || (v < BRD) || (v >= VV - BRD) || (h[TLG] ^ v[TLG]);
  endfunction

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d (n=%0d)", tag, what, got, exp, n);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic check_reset(string tag);
    chk(tag, "video_o", int'(video), 0);
    chk(tag, "hsync_o", int'(hs), 1);
    chk(tag, "vsync_o", int'(vs), 1);
    chk(tag, "rd_addr_o", int'(rd_addr), 0);
  endtask

  task automatic check_now(string ftag);
    int pa, ha, va, p, h, v, ea;
    bit vis_a, vis, lg;
    string tag;
    pa = n % FR; ha = pa % HT; va = pa / HT;
    vis_a = (ha < HV) && (va < VV);
    ea = vis_a ? (va / 2) * HV + ha : 0;
    if (ftag != "") tag = ftag;
    else if (vis_a && (va % 2 == 1)) tag = "R6";
    else tag = "R4";
    chk(tag, "rd_addr_o", int'(rd_addr), ea);
    if (n < 2) begin
      tag = (ftag != "") ? ftag : "R5";
      chk(tag, "video_o", int'(video), 0);
      chk(tag, "hsync_o", int'(hs), 1);
      chk(tag, "vsync_o", int'(vs), 1);
    end else begin
      p = (n - 2) % FR; h = p % HT; v = p / HT;
      vis = (h < HV) && (v < VV);
      lg = (n - 2) < LOGO;
      chk((ftag != "") ? ftag : "R2", "hsync_o", int'(hs),
          ((h >= HV + HF) && (h < HV + HF + HS)) ? 0 : 1);
      chk((ftag != "") ? ftag : "R3", "vsync_o", int'(vs),
          ((v >= VV + VF) && (v < VV + VF + VS)) ? 0 : 1);
      if (ftag != "") tag = ftag;
      else if (!vis) tag = "R7";
      else if (lg) tag = "R8";
      else tag = "R5";
      chk(tag, "video_o", int'(video),
          !vis ? 0 : (lg ? int'(logo_fn(h, v)) : int'(pix_fn(32'((v / 2) * HV + h)))));
    end
  endtask

  task automatic run(int k, string ftag);
    for (int i = 0; i < k; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      check_now(ftag);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    seed = $urandom;
    #1 rst_n = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check_reset("R1");
    end
    rst_n = 1'b1;
    n = 0;
    check_now("");
    // logo phase, then store content across two full frames
    run(LOGO + 2 * FR, "");
    run($urandom_range(1500, 200), "");
    // mid-frame reset with new store content
    @(negedge clk);
    rst_n = 1'b0;
    seed = $urandom;
    repeat ($urandom_range(9, 3)) begin
      @(negedge clk);
      check_reset("R9");
    end
    rst_n = 1'b1;
    n = 0;
    check_now("R9");
    run(FR, "R9");
    run(LOGO, "");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule